// File: doc/BRIEF.md
# Copy Channel Interrupt Controller

This block collects the interrupt causes of up to eight copy channels and folds them onto one shared interrupt line. The copy datapath reports finished transfers and error conditions as single-cycle pulses. The block also watches the current occupancy of each channel's source ring and destination ring. Every cause latches into a sticky status bit. Software clears a status bit by writing a one to it. Each cause also has an enable bit.

A single write port configures all channels. The port carries a channel number, a 3-bit register select and a data word. Per channel, software can write:

- the host enable bits and the error enable bits;
- the low and high watermark thresholds of both rings;
- a flag that keeps copy-complete off the interrupt, whatever its enable says.

The block reports one summary bit per channel. A summary bit is set while that channel has at least one enabled cause pending. An interrupt handler reads the summary vector and then services only the channels it flags. The shared line is a registered OR of the summary bits.

Top module: `copy_irq_ctrl`

## Requirements
- R1: After reset all status bits, summary bits and the interrupt line are 0, and all enables and the copy-complete-off flags are 0. Low thresholds reset to 0 and high thresholds reset to all ones, so no watermark cause can fire at any occupancy until software writes a threshold.
- R2: A pulse on a channel's copy event input sets host status bit 0 of that channel, visible after the next rising edge. The bit stays set afterwards.
- R3: A write with select 0 clears exactly those host status bits of the addressed channel whose mask bit is 1 in data[4:0]. Every other status bit keeps its value.
- R4: When a clear and a new event hit the same status bit in the same cycle, the bit ends up set.
- R5: Summary bit n is 1 exactly when channel n has a host status bit whose enable is also set, or an error status bit whose error enable is also set. Host enables are written with select 1 from data[4:0], one bit per host status bit.
- R6: A source error pulse sets error status bit 0 of the channel, and a destination error pulse sets error status bit 1. These bits reach the summary only through the error enable, written with select 2 from data[1:0]. Host enables have no effect on them. Select 3 clears error status bits by mask, the same way select 0 does for host bits.
- R7: Select 6 writes data[0] to the copy-complete-off flag of the channel. While the flag is 1, host status bit 0 never drives the summary, even when it is set and enabled. The bit itself still latches.
- R8: Select 4 writes the source ring thresholds and select 5 the destination ring thresholds: low in data[7:0], high in data[15:8]. The low cause sets once, on the first edge at which occupancy is below the low threshold after a cycle in which it was not. It is host status bit 2 for the source ring and bit 4 for the destination ring.
- R9: The high cause sets once, on the first edge at which occupancy is above the high threshold after a cycle in which it was not. It is host status bit 1 for the source ring and bit 3 for the destination ring.
- R10: The interrupt line equals the OR of all summary bits as they were one clock earlier.
- R11: A write touches only the channel it addresses. Select code 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Write strobe for the configuration port |
| cfg_ch | input | CH_W | Channel addressed by the write |
| cfg_sel | input | 3 | Register select code |
| cfg_wdata | input | 2*OCC_W | Write data or clear mask |
| ev_copy | input | NUM_CH | Copy-complete pulse, one bit per channel |
| ev_src_err | input | NUM_CH | Source-side error pulse, one bit per channel |
| ev_dst_err | input | NUM_CH | Destination-side error pulse, one bit per channel |
| src_occ | input | NUM_CH*OCC_W | Source ring occupancy, channel n in bits n*OCC_W upward |
| dst_occ | input | NUM_CH*OCC_W | Destination ring occupancy, same packing |
| host_stat_o | output | NUM_CH*5 | Host status bits, 5 per channel |
| err_stat_o | output | NUM_CH*2 | Error status bits, 2 per channel |
| summary_o | output | NUM_CH | Per-channel pending-enabled indication |
| irq_o | output | 1 | Shared interrupt line |

## Verification
The checker assumes every input holds a defined value from the first edge after reset. It also assumes that a status bit can only be cleared by a write with the matching clear select, addressed to that channel. The sticky and event-wins properties depend on that second assumption. The bench drives every input at the falling edge from known values. Its random writes cover all eight select codes, including the unused one, and all channel numbers, which the default eight channels fill completely. Occupancies move in small random steps with occasional jumps, so the watermark comparators see crossings in both directions, and thresholds are reprogrammed while a condition is already true.

// File: rtl/cic_pkg.sv
package cic_pkg;

    // Host status / enable layout (bit positions are visible to software)
    localparam int HS_W      = 5;
    localparam int HS_COPY   = 0;
    localparam int HS_SRC_HI = 1;
    localparam int HS_SRC_LO = 2;
    localparam int HS_DST_HI = 3;
    localparam int HS_DST_LO = 4;

    // Error status / enable layout
    localparam int ES_W   = 2;
    localparam int ES_SRC = 0;
    localparam int ES_DST = 1;

    localparam int SEL_W = 3;

    typedef enum logic [SEL_W-1:0] {
        SEL_HS_CLR = 3'd0,
        SEL_HS_EN  = 3'd1,
        SEL_ES_EN  = 3'd2,
        SEL_ES_CLR = 3'd3,
        SEL_SRC_WM = 3'd4,
        SEL_DST_WM = 3'd5,
        SEL_ATTR   = 3'd6,
        SEL_NONE   = 3'd7
    } cfg_sel_e;

    // Packed so that copy sits in bit 0 and dst_lo in bit 4
    typedef struct packed {
        logic dst_lo;
        logic dst_hi;
        logic src_lo;
        logic src_hi;
        logic copy;
    } host_cause_t;

    typedef struct packed {
        logic dst;
        logic src;
    } err_cause_t;

    // Sticky status update: new events take priority over a clear
    function automatic host_cause_t host_next(host_cause_t cur,
                                              logic [HS_W-1:0] clr,
                                              host_cause_t set);
        return host_cause_t'((cur & ~clr) | set);
    endfunction

    function automatic err_cause_t err_next(err_cause_t cur,
                                            logic [ES_W-1:0] clr,
                                            err_cause_t set);
        return err_cause_t'((cur & ~clr) | set);
    endfunction

endpackage

// File: rtl/cic_wm_cmp.sv
// Occupancy watermark comparator for one ring: emits a one-cycle cause
// when the below-low or above-high condition becomes true.
module cic_wm_cmp #(
    parameter int OCC_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [OCC_W-1:0] occ,
    input  logic [OCC_W-1:0] lo_thr,
    input  logic [OCC_W-1:0] hi_thr,
    output logic             lo_ev,
    output logic             hi_ev
);

    logic below, above;
    logic below_q, above_q;

    assign below = (occ < lo_thr);
    assign above = (occ > hi_thr);

    always_ff @(posedge clk) begin
        if (rst) begin
            below_q <= 1'b0;
            above_q <= 1'b0;
        end else begin
            below_q <= below;
            above_q <= above;
        end
    end

    assign lo_ev = below & ~below_q;
    assign hi_ev = above & ~above_q;

endmodule

// File: rtl/cic_chan.sv
// Per-channel status, enables, thresholds and pending indication.
module cic_chan
    import cic_pkg::*;
#(
    parameter int OCC_W = 8,
    localparam int DATA_W = 2 * OCC_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_hit,
    input  logic [SEL_W-1:0]  wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              ev_copy,
    input  logic              ev_src_err,
    input  logic              ev_dst_err,
    input  logic [OCC_W-1:0]  src_occ,
    input  logic [OCC_W-1:0]  dst_occ,
    output host_cause_t       host_stat,
    output err_cause_t        err_stat,
    output logic              pending
);

    host_cause_t      host_stat_q, host_en_q, host_set, host_en_eff;
    err_cause_t       err_stat_q, err_en_q, err_set;
    logic [OCC_W-1:0] src_lo_q, src_hi_q, dst_lo_q, dst_hi_q;
    logic             cc_off_q;
    logic [HS_W-1:0]  host_clr;
    logic [ES_W-1:0]  err_clr;
    logic             src_lo_ev, src_hi_ev, dst_lo_ev, dst_hi_ev;
    cfg_sel_e         sel;

    assign sel = cfg_sel_e'(wr_sel);

    cic_wm_cmp #(.OCC_W(OCC_W)) u_src_wm (
        .clk    (clk),
        .rst    (rst),
        .occ    (src_occ),
        .lo_thr (src_lo_q),
        .hi_thr (src_hi_q),
        .lo_ev  (src_lo_ev),
        .hi_ev  (src_hi_ev)
    );

    cic_wm_cmp #(.OCC_W(OCC_W)) u_dst_wm (
        .clk    (clk),
        .rst    (rst),
        .occ    (dst_occ),
        .lo_thr (dst_lo_q),
        .hi_thr (dst_hi_q),
        .lo_ev  (dst_lo_ev),
        .hi_ev  (dst_hi_ev)
    );

    always_comb begin
        host_set        = '0;
        host_set.copy   = ev_copy;
        host_set.src_hi = src_hi_ev;
        host_set.src_lo = src_lo_ev;
        host_set.dst_hi = dst_hi_ev;
        host_set.dst_lo = dst_lo_ev;

        err_set     = '0;
        err_set.src = ev_src_err;
        err_set.dst = ev_dst_err;

        host_clr = (wr_hit && sel == SEL_HS_CLR) ? wr_data[HS_W-1:0] : '0;
        err_clr  = (wr_hit && sel == SEL_ES_CLR) ? wr_data[ES_W-1:0] : '0;

        host_en_eff      = host_en_q;
        host_en_eff.copy = host_en_q.copy & ~cc_off_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            host_stat_q <= '0;
            err_stat_q  <= '0;
            host_en_q   <= '0;
            err_en_q    <= '0;
            src_lo_q    <= '0;
            dst_lo_q    <= '0;
            src_hi_q    <= '1;
            dst_hi_q    <= '1;
            cc_off_q    <= 1'b0;
        end else begin
            host_stat_q <= host_next(host_stat_q, host_clr, host_set);
            err_stat_q  <= err_next(err_stat_q, err_clr, err_set);
            if (wr_hit) begin
                case (sel)
                    SEL_HS_EN:  host_en_q <= host_cause_t'(wr_data[HS_W-1:0]);
                    SEL_ES_EN:  err_en_q  <= err_cause_t'(wr_data[ES_W-1:0]);
                    SEL_SRC_WM: begin
                        src_lo_q <= wr_data[OCC_W-1:0];
                        src_hi_q <= wr_data[DATA_W-1:OCC_W];
                    end
                    SEL_DST_WM: begin
                        dst_lo_q <= wr_data[OCC_W-1:0];
                        dst_hi_q <= wr_data[DATA_W-1:OCC_W];
                    end
                    SEL_ATTR:   cc_off_q <= wr_data[0];
                    default: ;
                endcase
            end
        end
    end

    assign host_stat = host_stat_q;
    assign err_stat  = err_stat_q;
    assign pending   = (|(host_stat_q & host_en_eff)) | (|(err_stat_q & err_en_q));

endmodule

// File: rtl/copy_irq_ctrl.sv
// Interrupt aggregation for NUM_CH copy channels onto one shared line.
module copy_irq_ctrl
    import cic_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int OCC_W  = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DATA_W = 2 * OCC_W
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    cfg_we,
    input  logic [CH_W-1:0]         cfg_ch,
    input  logic [SEL_W-1:0]        cfg_sel,
    input  logic [DATA_W-1:0]       cfg_wdata,
    input  logic [NUM_CH-1:0]       ev_copy,
    input  logic [NUM_CH-1:0]       ev_src_err,
    input  logic [NUM_CH-1:0]       ev_dst_err,
    input  logic [NUM_CH*OCC_W-1:0] src_occ,
    input  logic [NUM_CH*OCC_W-1:0] dst_occ,
    output logic [NUM_CH*HS_W-1:0]  host_stat_o,
    output logic [NUM_CH*ES_W-1:0]  err_stat_o,
    output logic [NUM_CH-1:0]       summary_o,
    output logic                    irq_o
);

    logic [NUM_CH-1:0] pend;
    logic              irq_q;

    for (genvar n = 0; n < NUM_CH; n++) begin : g_ch
        logic        hit;
        host_cause_t hs;
        err_cause_t  es;

        assign hit = cfg_we && (cfg_ch == CH_W'(n));

        cic_chan #(.OCC_W(OCC_W)) u_chan (
            .clk        (clk),
            .rst        (rst),
            .wr_hit     (hit),
            .wr_sel     (cfg_sel),
            .wr_data    (cfg_wdata),
            .ev_copy    (ev_copy[n]),
            .ev_src_err (ev_src_err[n]),
            .ev_dst_err (ev_dst_err[n]),
            .src_occ    (src_occ[n*OCC_W +: OCC_W]),
            .dst_occ    (dst_occ[n*OCC_W +: OCC_W]),
            .host_stat  (hs),
            .err_stat   (es),
            .pending    (pend[n])
        );

        assign host_stat_o[n*HS_W +: HS_W] = hs;
        assign err_stat_o[n*ES_W +: ES_W]  = es;
    end

    always_ff @(posedge clk) begin
        if (rst) irq_q <= 1'b0;
        else     irq_q <= |pend;
    end

    assign summary_o = pend;
    assign irq_o     = irq_q;

endmodule

// File: rtl/cic_checker.sv
module cic_checker
    import cic_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int OCC_W  = 8,
    localparam int CH_W   = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int DATA_W = 2 * OCC_W
) (
    input logic                   clk,
    input logic                   rst,
    input logic                   cfg_we,
    input logic [CH_W-1:0]        cfg_ch,
    input logic [SEL_W-1:0]       cfg_sel,
    input logic [DATA_W-1:0]      cfg_wdata,
    input logic [NUM_CH-1:0]      ev_copy,
    input logic [NUM_CH-1:0]      ev_src_err,
    input logic [NUM_CH-1:0]      ev_dst_err,
    input logic [NUM_CH*HS_W-1:0] host_stat_o,
    input logic [NUM_CH*ES_W-1:0] err_stat_o,
    input logic [NUM_CH-1:0]      summary_o,
    input logic                   irq_o
);

    p_irq_high_r10: assert property (@(posedge clk) disable iff (rst)
        (|summary_o) |=> irq_o);
    p_irq_low_r10: assert property (@(posedge clk) disable iff (rst)
        !(|summary_o) |=> !irq_o);

    for (genvar n = 0; n < NUM_CH; n++) begin : g_chk
        logic hs_clr_wr;
        assign hs_clr_wr = cfg_we && (cfg_ch == CH_W'(n)) && (cfg_sel == SEL_HS_CLR);

        p_copy_sets_r2: assert property (@(posedge clk) disable iff (rst)
            ev_copy[n] |=> host_stat_o[n*HS_W + HS_COPY]);

        p_event_wins_r4: assert property (@(posedge clk) disable iff (rst)
            (ev_copy[n] && hs_clr_wr && cfg_wdata[HS_COPY])
            |=> host_stat_o[n*HS_W + HS_COPY]);

        p_err_src_sets_r6: assert property (@(posedge clk) disable iff (rst)
            ev_src_err[n] |=> err_stat_o[n*ES_W + ES_SRC]);

        p_err_dst_sets_r6: assert property (@(posedge clk) disable iff (rst)
            ev_dst_err[n] |=> err_stat_o[n*ES_W + ES_DST]);

        p_summary_cause_r5: assert property (@(posedge clk) disable iff (rst)
            summary_o[n] |-> ((|host_stat_o[n*HS_W +: HS_W]) ||
                              (|err_stat_o[n*ES_W +: ES_W])));

        for (genvar b = 0; b < HS_W; b++) begin : g_bit
            p_sticky_r3: assert property (@(posedge clk) disable iff (rst)
                (host_stat_o[n*HS_W + b] && !(hs_clr_wr && cfg_wdata[b]))
                |=> host_stat_o[n*HS_W + b]);
        end
    end

endmodule

bind copy_irq_ctrl cic_checker #(.NUM_CH(NUM_CH), .OCC_W(OCC_W)) u_cic_checker (
    .clk         (clk),
    .rst         (rst),
    .cfg_we      (cfg_we),
    .cfg_ch      (cfg_ch),
    .cfg_sel     (cfg_sel),
    .cfg_wdata   (cfg_wdata),
    .ev_copy     (ev_copy),
    .ev_src_err  (ev_src_err),
    .ev_dst_err  (ev_dst_err),
    .host_stat_o (host_stat_o),
    .err_stat_o  (err_stat_o),
    .summary_o   (summary_o),
    .irq_o       (irq_o)
);

// File: tb/copy_irq_ctrl_bench.sv
module copy_irq_ctrl_bench;

    localparam int NCH = 8;
    localparam int OW  = 8;
    localparam int HSW = 5;
    localparam int ESW = 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              cfg_we = 1'b0;
    logic [2:0]        cfg_ch = '0;
    logic [2:0]        cfg_sel = '0;
    logic [2*OW-1:0]   cfg_wdata = '0;
    logic [NCH-1:0]    ev_copy = '0, ev_src_err = '0, ev_dst_err = '0;
    logic [NCH*OW-1:0] src_occ = '0, dst_occ = '0;
    logic [NCH*HSW-1:0] host_stat_o;
    logic [NCH*ESW-1:0] err_stat_o;
    logic [NCH-1:0]     summary_o;
    logic               irq_o;

    always #10 clk = ~clk;   // 50 MHz

    copy_irq_ctrl #(.NUM_CH(NCH), .OCC_W(OW)) u_copy_irq_ctrl (
        .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .ev_copy(ev_copy), .ev_src_err(ev_src_err),
        .ev_dst_err(ev_dst_err), .src_occ(src_occ), .dst_occ(dst_occ),
        .host_stat_o(host_stat_o), .err_stat_o(err_stat_o),
        .summary_o(summary_o), .irq_o(irq_o)
    );

    // Reference model state
    logic [HSW-1:0] m_hs [NCH], m_he [NCH];
    logic [ESW-1:0] m_es [NCH], m_me [NCH];
    logic [OW-1:0]  m_slo [NCH], m_shi [NCH], m_dlo [NCH], m_dhi [NCH];
    logic           m_off [NCH], m_sb [NCH], m_sa [NCH], m_db [NCH], m_da [NCH];
    logic           m_irq;

    int n_checks = 0;
    int n_fail   = 0;
    int cycles   = 0;
    bit done     = 0;

    function automatic logic exp_sum(int n);
        logic [HSW-1:0] en;
        en = m_he[n];
        en[0] = en[0] & ~m_off[n];
        return (|(m_hs[n] & en)) | (|(m_es[n] & m_me[n]));
    endfunction

    task automatic model_reset();
        for (int n = 0; n < NCH; n++) begin
            m_hs[n] = '0; m_he[n] = '0; m_es[n] = '0; m_me[n] = '0;
            m_slo[n] = '0; m_dlo[n] = '0; m_shi[n] = '1; m_dhi[n] = '1;
            m_off[n] = 0; m_sb[n] = 0; m_sa[n] = 0; m_db[n] = 0; m_da[n] = 0;
        end
        m_irq = 0;
    endtask

    task automatic model_update();
        logic nirq;
        nirq = 0;
        for (int n = 0; n < NCH; n++) nirq |= exp_sum(n);
        for (int n = 0; n < NCH; n++) begin
            logic [OW-1:0] so, dso;
            logic sb, sa, db, da, hit;
            logic [HSW-1:0] set, clr;
            logic [ESW-1:0] eclr;
            so  = src_occ[n*OW +: OW];
            dso = dst_occ[n*OW +: OW];
            sb = so < m_slo[n];  sa = so > m_shi[n];
            db = dso < m_dlo[n]; da = dso > m_dhi[n];
            set = {db & ~m_db[n], da & ~m_da[n], sb & ~m_sb[n], sa & ~m_sa[n], ev_copy[n]};
            hit = cfg_we && (int'(cfg_ch) == n);
            clr  = (hit && cfg_sel == 3'd0) ? cfg_wdata[HSW-1:0] : '0;
            eclr = (hit && cfg_sel == 3'd3) ? cfg_wdata[ESW-1:0] : '0;
            m_hs[n] = (m_hs[n] & ~clr) | set;
            m_es[n] = (m_es[n] & ~eclr) | {ev_dst_err[n], ev_src_err[n]};
            m_sb[n] = sb; m_sa[n] = sa; m_db[n] = db; m_da[n] = da;
            if (hit) begin
                case (cfg_sel)
                    3'd1: m_he[n] = cfg_wdata[HSW-1:0];
                    3'd2: m_me[n] = cfg_wdata[ESW-1:0];
                    3'd4: begin m_slo[n] = cfg_wdata[OW-1:0]; m_shi[n] = cfg_wdata[2*OW-1:OW]; end
                    3'd5: begin m_dlo[n] = cfg_wdata[OW-1:0]; m_dhi[n] = cfg_wdata[2*OW-1:OW]; end
                    3'd6: m_off[n] = cfg_wdata[0];
                    default: ;
                endcase
            end
        end
        m_irq = nirq;
    endtask

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic compare_all(string req);
        logic [NCH*HSW-1:0] hs;
        logic [NCH*ESW-1:0] es;
        logic [NCH-1:0]     sm;
        for (int n = 0; n < NCH; n++) begin
            hs[n*HSW +: HSW] = m_hs[n];
            es[n*ESW +: ESW] = m_es[n];
            sm[n] = exp_sum(n);
        end
        chk(req, 64'(host_stat_o), 64'(hs));
        chk(req, 64'(err_stat_o), 64'(es));
        chk(req, 64'(summary_o), 64'(sm));
        chk(req, 64'(irq_o), 64'(m_irq));
    endtask

    task automatic tick();
        @(posedge clk);
        if (!rst) model_update();
        @(negedge clk);
        cfg_we = 0; ev_copy = '0; ev_src_err = '0; ev_dst_err = '0;
    endtask

    task automatic wr(int ch, int sel, logic [2*OW-1:0] data);
        cfg_we = 1; cfg_ch = 3'(ch); cfg_sel = 3'(sel); cfg_wdata = data;
        tick();
    endtask

    task automatic set_all_occ(logic [OW-1:0] v);
        for (int n = 0; n < NCH; n++) begin
            src_occ[n*OW +: OW] = v;
            dst_occ[n*OW +: OW] = v;
        end
    endtask

    // Watchdog
    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 150000 && !done) begin
                n_checks++; n_fail++;
                $display("FAIL R11: watchdog got %0d cycles expected under 150000", cycles);
                $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'h1C0DE5));
        model_reset();
        repeat (3) @(negedge clk);
        rst = 0;
        tick();
        // R1: reset state
        chk("R1", 64'(host_stat_o), 0);
        chk("R1", 64'(summary_o), 0);
        chk("R1", 64'(irq_o), 0);
        set_all_occ(8'h00); tick(); tick();
        chk("R1", 64'(host_stat_o), 0);     // low threshold 0: no low cause
        set_all_occ(8'hFF); tick(); tick();
        chk("R1", 64'(host_stat_o), 0);     // high threshold all ones: no high cause
        compare_all("R1");
        set_all_occ(8'd15); tick();

        // R2: copy event latches and stays
        ev_copy[2] = 1; tick();
        chk("R2", 64'(host_stat_o[2*HSW]), 1);
        chk("R5", 64'(summary_o), 0);
        tick(); tick();
        chk("R2", 64'(host_stat_o[2*HSW]), 1);

        // R5 / R10: enable, summary then irq one cycle later
        wr(2, 1, 16'h0001);
        chk("R5", 64'(summary_o), 64'h04);
        chk("R10", 64'(irq_o), 0);
        tick();
        chk("R10", 64'(irq_o), 1);

        // R7: copy-complete forced off
        wr(2, 6, 16'h0001);
        chk("R7", 64'(summary_o[2]), 0);
        chk("R7", 64'(host_stat_o[2*HSW]), 1);
        tick();
        chk("R10", 64'(irq_o), 0);
        wr(2, 6, 16'h0000);
        chk("R7", 64'(summary_o[2]), 1);

        // R3: W1C exactness
        wr(2, 0, 16'h001E);
        chk("R3", 64'(host_stat_o[2*HSW +: HSW]), 64'h01);
        wr(2, 0, 16'h0001);
        chk("R3", 64'(host_stat_o[2*HSW +: HSW]), 64'h00);
        chk("R5", 64'(summary_o), 0);

        // R4: clear and event in the same cycle
        ev_copy[2] = 1; wr(2, 0, 16'h001F);
        chk("R4", 64'(host_stat_o[2*HSW]), 1);
        compare_all("R4");

        // R6: error causes use only the error enable
        wr(5, 1, 16'h001F);
        ev_src_err[5] = 1; tick();
        chk("R6", 64'(err_stat_o[5*ESW +: ESW]), 64'h1);
        chk("R6", 64'(summary_o[5]), 0);
        wr(5, 2, 16'h0001);
        chk("R6", 64'(summary_o[5]), 1);
        ev_dst_err[5] = 1; wr(5, 3, 16'h0001);
        chk("R6", 64'(err_stat_o[5*ESW +: ESW]), 64'h2);
        chk("R6", 64'(summary_o[5]), 0);
        compare_all("R6");

        // R8 / R9: watermarks on channel 1
        wr(1, 4, {8'd20, 8'd10});
        wr(1, 5, {8'd20, 8'd10});
        chk("R8", 64'(host_stat_o[1*HSW +: HSW]), 0);
        src_occ[1*OW +: OW] = 8'd5; tick();
        chk("R8", 64'(host_stat_o[1*HSW +: HSW]), 64'h04);
        wr(1, 0, 16'h0004); tick();
        chk("R8", 64'(host_stat_o[1*HSW +: HSW]), 0);   // no refire while held low
        src_occ[1*OW +: OW] = 8'd25; tick();
        chk("R9", 64'(host_stat_o[1*HSW +: HSW]), 64'h02);
        dst_occ[1*OW +: OW] = 8'd3; tick();
        chk("R8", 64'(host_stat_o[1*HSW +: HSW]), 64'h12);
        dst_occ[1*OW +: OW] = 8'd30; tick();
        chk("R9", 64'(host_stat_o[1*HSW +: HSW]), 64'h1A);
        compare_all("R9");

        // R11: unused select and cross-channel isolation
        wr(3, 7, 16'hFFFF);
        compare_all("R11");

        // Random phase
        for (int i = 0; i < 4000; i++) begin
            ev_copy    = NCH'($urandom & $urandom & $urandom);
            ev_src_err = NCH'($urandom & $urandom & $urandom & $urandom);
            ev_dst_err = NCH'($urandom & $urandom & $urandom & $urandom);
            for (int n = 0; n < NCH; n++) begin
                int v;
                v = int'(src_occ[n*OW +: OW]);
                v = ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 255))
                                                  : v + int'($urandom_range(0, 6)) - 3;
                src_occ[n*OW +: OW] = OW'((v < 0) ? 0 : (v > 255) ? 255 : v);
                v = int'(dst_occ[n*OW +: OW]);
                v = ($urandom_range(0, 15) == 0) ? int'($urandom_range(0, 255))
                                                  : v + int'($urandom_range(0, 6)) - 3;
                dst_occ[n*OW +: OW] = OW'((v < 0) ? 0 : (v > 255) ? 255 : v);
            end
            if ($urandom_range(0, 3) == 0) begin
                cfg_we = 1;
                cfg_ch = 3'($urandom_range(0, 7));
                cfg_sel = 3'($urandom_range(0, 7));
                cfg_wdata = 16'($urandom);
            end
            tick();
            compare_all("R11");
        end

        done = 1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule